// File: doc/BRIEF.md
# GPIO Interrupt Detector

This block turns the synchronised input values of a small I/O port into interrupt requests. Every pin has its own detector. The detector either follows a level or latches an edge, and three byte-wide configuration registers choose how each pin is sensed. Software reaches the block through a simple single-cycle register port. The port gives a raw status view and a masked status view, an enable mask, and a write-one-to-clear register for edge events that have been latched.

A level-sensitive pin reports its condition for as long as the pin holds the active level. An edge-sensitive pin remembers the edge until software clears it. The enabled status bits are ORed together and registered, and the result drives a single interrupt line towards the system interrupt controller.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low. Registers at word offsets: sense 0x404, dual-edge 0x408, polarity 0x40C, enable 0x410, raw 0x414, masked 0x418, clear 0x41C.
- R2: A pin whose sense bit is 1 and whose polarity bit is 1 shows raw status 1 in the same cycle that its level is high, and 0 when the level is low.
- R3: A pin whose sense bit is 1 and whose polarity bit is 0 shows raw status 1 while its level is low.
- R4: A level-sensitive raw bit stays at 1 after a clear write to that bit, for as long as the level stays active.
- R5: A pin with sense 0, dual-edge 0 and polarity 1 latches raw status 1 one clock after a rising edge, and a falling edge does not set it.
- R6: A pin with sense 0, dual-edge 0 and polarity 0 latches on a falling edge only.
- R7: A pin with sense 0 and dual-edge 1 latches on either edge, whatever its polarity bit holds.
- R8: Writing 1 to a bit of the clear register clears that latched edge bit. Bits written 0 leave the status unchanged. The clear register reads 0.
- R9: When a new edge and a clear of the same bit fall in the same cycle, the bit stays set.
- R10: The masked status reads as raw AND enable. The raw status is reported whatever the enable mask holds.
- R11: `irq_o` is the OR of all masked bits, delayed by one register stage.
- R12: Writing 0 to the enable register forces `irq_o` low from the following cycle on.
- R13: The sense, dual-edge, polarity and enable registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_i | input | NPINS | Synchronised pin values |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
The bench builds the block with its default of eight pins, so that one write covers every pin and each byte pattern runs all eight detectors side by side. One vector row can therefore mix level, single-edge and dual-edge pins with both polarities at once. The directed tests then cover the clear-versus-edge race on a chosen bit, the cycle of latency on the interrupt line, and the effect of an all-zero enable mask.

// File: rtl/gid_pkg.sv
package gid_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_SENSE  = 12'h404;
  localparam logic [ADDR_W-1:0] OFS_DUAL   = 12'h408;
  localparam logic [ADDR_W-1:0] OFS_POL    = 12'h40C;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 12'h410;
  localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h414;
  localparam logic [ADDR_W-1:0] OFS_MASKED = 12'h418;
  localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h41C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SENSE, SEL_DUAL, SEL_POL,
    SEL_ENABLE, SEL_RAW, SEL_MASKED, SEL_CLEAR
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] a);
    case (a)
      OFS_SENSE:  return SEL_SENSE;
      OFS_DUAL:   return SEL_DUAL;
      OFS_POL:    return SEL_POL;
      OFS_ENABLE: return SEL_ENABLE;
      OFS_RAW:    return SEL_RAW;
      OFS_MASKED: return SEL_MASKED;
      OFS_CLEAR:  return SEL_CLEAR;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gid_rst_sync.sv
module gid_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/gid_regs.sv
module gid_regs
  import gid_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  input  logic [NPINS-1:0]  raw_i,
  input  logic [NPINS-1:0]  masked_i,
  output logic [NPINS-1:0]  sense_o,
  output logic [NPINS-1:0]  dual_o,
  output logic [NPINS-1:0]  pol_o,
  output logic [NPINS-1:0]  enable_o,
  output logic [NPINS-1:0]  clr_o,
  output logic [NPINS-1:0]  rdata
);
  reg_sel_e sel;
  logic [NPINS-1:0] sense_q, dual_q, pol_q, enable_q;
  logic [NPINS-1:0] sense_d, dual_d, pol_d, enable_d;
  logic sense_en, dual_en, pol_en, enable_en;

  always_comb begin
    sel       = decode_addr(addr);
    sense_en  = wr_en && (sel == SEL_SENSE);
    dual_en   = wr_en && (sel == SEL_DUAL);
    pol_en    = wr_en && (sel == SEL_POL);
    enable_en = wr_en && (sel == SEL_ENABLE);
    sense_d   = sense_en  ? wdata : sense_q;
    dual_d    = dual_en   ? wdata : dual_q;
    pol_d     = pol_en    ? wdata : pol_q;
    enable_d  = enable_en ? wdata : enable_q;
    clr_o     = (wr_en && (sel == SEL_CLEAR)) ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q  <= '0;
      dual_q   <= '0;
      pol_q    <= '0;
      enable_q <= '0;
    end else begin
      sense_q  <= sense_d;
      dual_q   <= dual_d;
      pol_q    <= pol_d;
      enable_q <= enable_d;
    end
  end

  always_comb begin
    case (sel)
      SEL_SENSE:  rdata = sense_q;
      SEL_DUAL:   rdata = dual_q;
      SEL_POL:    rdata = pol_q;
      SEL_ENABLE: rdata = enable_q;
      SEL_RAW:    rdata = raw_i;
      SEL_MASKED: rdata = masked_i;
      default:    rdata = '0;
    endcase
  end

  assign sense_o  = sense_q;
  assign dual_o   = dual_q;
  assign pol_o    = pol_q;
  assign enable_o = enable_q;

  // R12
  enable_zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel == SEL_ENABLE) && (wdata == '0)) |=> (enable_o == '0));

  // R13
  sense_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (sel == SEL_SENSE)) |=> $stable(sense_o));
endmodule

// File: rtl/gid_pin_detect.sv
module gid_pin_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic level_mode_i,
  input  logic dual_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic raw_o
);
  logic prev_q, prev_d;
  logic latch_q, latch_d;
  logic rise, fall, hit;

  always_comb begin
    rise    = pin_i & ~prev_q;
    fall    = ~pin_i & prev_q;
    hit     = dual_i ? (rise | fall) : (pol_i ? rise : fall);
    prev_d  = pin_i;
    latch_d = ~level_mode_i & (hit | (latch_q & ~clr_i));
    raw_o   = level_mode_i ? (pin_i == pol_i) : latch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      latch_q <= latch_d;
    end
  end

  // R9
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode_i && hit) |=> latch_q);

  // R8
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode_i && clr_i && !hit) |=> !latch_q);

  // R4
  level_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_mode_i |=> !latch_q);
endmodule

// File: rtl/gid_irq_combine.sv
module gid_irq_combine #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] raw_i,
  input  logic [NPINS-1:0] enable_i,
  output logic [NPINS-1:0] masked_o,
  output logic             irq_o
);
  logic irq_q, irq_d;

  always_comb begin
    masked_o = raw_i & enable_i;
    irq_d    = |masked_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R12
  mask_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i == '0) |=> !irq_o);

  // R11
  raw_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_i == '0) |=> !irq_o);
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gid_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  output logic              irq_o
);
  logic rst_sync_n;
  logic [NPINS-1:0] sense, dual, pol, enable, clr, raw, masked;

  gid_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gid_regs #(.NPINS(NPINS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .raw_i    (raw),
    .masked_i (masked),
    .sense_o  (sense),
    .dual_o   (dual),
    .pol_o    (pol),
    .enable_o (enable),
    .clr_o    (clr),
    .rdata    (bus_rdata)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gid_pin_detect u_det (
      .clk          (clk),
      .rst_n        (rst_sync_n),
      .pin_i        (pin_i[i]),
      .level_mode_i (sense[i]),
      .dual_i       (dual[i]),
      .pol_i        (pol[i]),
      .clr_i        (clr[i]),
      .raw_o        (raw[i])
    );
  end

  gid_irq_combine #(.NPINS(NPINS)) u_comb (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .raw_i    (raw),
    .enable_i (enable),
    .masked_o (masked),
    .irq_o    (irq_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_n |=> !irq_o);
endmodule

// File: tb/sim_gpio_irq_detect.sv
`timescale 1ns/1ps
module sim_gpio_irq_detect;
  localparam int NPINS = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NPINS-1:0] pin_i;
  logic             bus_wr;
  logic [11:0]      bus_addr;
  logic [NPINS-1:0] bus_wdata;
  logic [NPINS-1:0] bus_rdata;
  logic             irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  localparam logic [11:0] A_SENSE = 12'h404, A_DUAL = 12'h408, A_POL = 12'h40C,
                          A_EN = 12'h410, A_RAW = 12'h414, A_MSK = 12'h418,
                          A_CLR = 12'h41C;

  // fields: sense, dual, polarity, pins before, pins after, expected raw
  localparam logic [47:0] VEC [6] = '{
    {8'hFF, 8'h00, 8'hF0, 8'h00, 8'hCC, 8'hC3},  // R2 R3 level, both polarities
    {8'h00, 8'h00, 8'hFF, 8'h0F, 8'hF0, 8'hF0},  // R5 rising only
    {8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'h0F},  // R6 falling only
    {8'h00, 8'hFF, 8'h55, 8'h33, 8'hA5, 8'h96},  // R7 both edges, polarity ignored
    {8'h0F, 8'h30, 8'hC5, 8'h00, 8'hFF, 8'hF5},  // R2 R3 R5 R7 mixed, rising
    {8'h0F, 8'h30, 8'hC5, 8'hFF, 8'h00, 8'h3A}   // R2 R3 R5 R7 mixed, falling
  };

  gpio_irq_detect #(.NPINS(NPINS)) u0 (
    .clk, .rst_n, .pin_i, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .irq_o
  );

  always #2.5 clk = ~clk;

  task automatic check(string req, logic [NPINS-1:0] act, logic [NPINS-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [NPINS-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(string req, logic [11:0] a, logic [NPINS-1:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin_i = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_check("R1 sense", A_SENSE, 8'h00);
    rd_check("R1 dual", A_DUAL, 8'h00);
    rd_check("R1 pol", A_POL, 8'h00);
    rd_check("R1 enable", A_EN, 8'h00);
    rd_check("R1 raw", A_RAW, 8'h00);
    rd_check("R1 masked", A_MSK, 8'h00);
    rd_check("R1 clear", A_CLR, 8'h00);
    check("R1 irq", {7'b0, irq_o}, 8'h00);

    // R13 readback
    wr(A_SENSE, 8'hA5); rd_check("R13 sense", A_SENSE, 8'hA5);
    wr(A_DUAL, 8'h3C);  rd_check("R13 dual", A_DUAL, 8'h3C);
    wr(A_POL, 8'h69);   rd_check("R13 pol", A_POL, 8'h69);
    wr(A_EN, 8'h0F);    rd_check("R13 enable", A_EN, 8'h0F);
    wr(A_EN, 8'h00);

    // vector table
    foreach (VEC[i]) begin
      wr(A_SENSE, VEC[i][47:40]);
      wr(A_DUAL,  VEC[i][39:32]);
      wr(A_POL,   VEC[i][31:24]);
      @(negedge clk) pin_i = VEC[i][23:16];
      repeat (2) @(negedge clk);
      wr(A_CLR, 8'hFF);
      pin_i = VEC[i][15:8];
      rd_check($sformatf("R2 R3 R5 R6 R7 row %0d", i), A_RAW, VEC[i][7:0]);
    end

    // R8 clear behaviour
    wr(A_SENSE, 8'h00); wr(A_DUAL, 8'h00); wr(A_POL, 8'hFF); wr(A_EN, 8'h00);
    @(negedge clk) pin_i = 8'h00;
    wr(A_CLR, 8'hFF);
    pin_i = 8'hFF;
    rd_check("R5 all rising", A_RAW, 8'hFF);
    wr(A_CLR, 8'h0F); rd_check("R8 clear low nibble", A_RAW, 8'hF0);
    wr(A_CLR, 8'h00); rd_check("R8 zero bits no effect", A_RAW, 8'hF0);
    rd_check("R8 clear reads 0", A_CLR, 8'h00);

    // R10 R11 R12 mask and interrupt line
    wr(A_EN, 8'h3C);
    check("R11 irq one stage late", {7'b0, irq_o}, 8'h00);
    @(negedge clk) check("R11 irq set", {7'b0, irq_o}, 8'h01);
    rd_check("R10 masked", A_MSK, 8'h30);
    rd_check("R10 raw unmasked", A_RAW, 8'hF0);
    wr(A_EN, 8'h00);
    check("R11 irq holds one cycle", {7'b0, irq_o}, 8'h01);
    @(negedge clk) check("R12 irq off", {7'b0, irq_o}, 8'h00);
    rd_check("R10 raw with mask 0", A_RAW, 8'hF0);
    rd_check("R12 masked 0", A_MSK, 8'h00);

    // R9 edge and clear in the same cycle
    @(negedge clk) pin_i = 8'hFE;
    wr(A_CLR, 8'hFF);
    rd_check("R8 all cleared", A_RAW, 8'h00);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 8'h03; pin_i = 8'hFF;
    @(negedge clk) bus_wr = 1'b0;
    rd_check("R9 edge beats clear", A_RAW, 8'h01);

    // R4 level not clearable while active
    wr(A_SENSE, 8'h01); wr(A_POL, 8'h01);
    wr(A_CLR, 8'h01);
    rd_check("R4 level survives clear", A_RAW, 8'h01);
    @(negedge clk) pin_i = 8'hFE;
    rd_check("R2 level drops with pin", A_RAW, 8'h00);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule